// File: doc/BRIEF.md
# Bus Error Machine-Check Logger

This block monitors the processor's external bus for two kinds of failed cycle. The first is a bus-check fault flagged by system logic. The second is a data-bus parity fault, which counts only while system logic enables parity checking. When a cycle fails, the block records two things whether or not exceptions are enabled: the cycle's physical address and a word that describes the cycle's kind. Each goes into its own 64-bit register.

A single machine-check enable input decides whether the failure also raises an exception request. This input is bit 6 of the fourth control register, and it gates vector 12h. When the enable is clear, no request is made and execution carries on, but the captured record is still written.

Software reads both records through an indexed read port, in the manner of a model-specific register read. The bus protocol itself, the parity computation and the delivery of the exception are all handled elsewhere.

Top module: `buserr_mc_logger`

## Requirements
- R1: After reset, both capture registers hold zero, and `mc_req_o`, `rd_valid_o` and `rd_data_o` are all 0.
- R2: On a failed cycle, the address register takes the 32-bit physical address zero-extended to 64 bits, so bits 63..32 are 0.
- R3: A failed cycle is recognised when `bus_chk_i` is 1, or when `par_chk_i` and `par_en_i` are both 1. Either parity signal alone has no effect on any register or output.
- R4: On a failed cycle, the type register takes bit 0 = write (1) or read (0), bit 1 = data (1) or code (0), bit 2 = memory (1) or I/O (0), bit 3 = locked, and bit 4 = cache-line fill. Bits 63..5 are 0.
- R5: When a failed cycle is sampled at a clock edge with `mce_i` = 1, `mc_req_o` is 1 for the one cycle after that edge. `mc_req_o` is 0 in every other cycle.
- R6: When `mce_i` = 0, a failed cycle raises no request, but both capture registers are still updated.
- R7: A read sampled with `rd_en_i` = 1 drives `rd_valid_o` = 1 in the next cycle. In that cycle `rd_data_o` carries the address register for index 0x00, the type register for index 0x01, and zero for any other index. Without a read, `rd_valid_o` is 0 and `rd_data_o` holds its last value.
- R8: If a failed cycle and a read are sampled at the same edge, the capture takes effect, and the read returns the newly captured value.
- R9: Every failed cycle overwrites both registers, so the last one wins. A cycle with no failure leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_chk_i | input | 1 | Bus-check fault flagged by system logic |
| par_chk_i | input | 1 | Processor's data parity check result |
| par_en_i | input | 1 | Parity checking enabled by system logic |
| mce_i | input | 1 | Machine-check enable (control register 4, bit 6) |
| cyc_addr_i | input | PADDR_W | Physical address of the current cycle |
| cyc_wr_i | input | 1 | Cycle is a write |
| cyc_data_i | input | 1 | Cycle is a data access, not a code fetch |
| cyc_mem_i | input | 1 | Cycle targets memory, not I/O |
| cyc_lock_i | input | 1 | Cycle is locked |
| cyc_fill_i | input | 1 | Cycle is a cache-line fill |
| rd_en_i | input | 1 | Register read request |
| rd_idx_i | input | IDX_W | Register read index |
| rd_data_o | output | REG_W | Read data |
| rd_valid_o | output | 1 | Read data valid |
| mc_req_o | output | 1 | Machine-check exception request pulse |

## Verification
Suppose the error qualifier is wrong, for example if a lone parity-check signal is accepted. Then the captured address changes, and the very next read of index 0 shows the stray value one cycle after the read. A request that comes out of phase or is not gated by the enable shows at `mc_req_o` in the cycle right after the faulty edge. A wrong field order in the type word, or a read that ignores the same-edge capture, shows on the first read after the affected error.

// File: rtl/mcl_pkg.sv
package mcl_pkg;

  localparam int TYPE_BITS = 5;
  localparam int IDX_ADDR  = 0;
  localparam int IDX_TYPE  = 1;

  // Attribute bits of a bus cycle; last member lands in bit 0.
  typedef struct packed {
    logic fill;
    logic lock;
    logic mem;
    logic data;
    logic wr;
  } cyc_attr_t;

  function automatic logic [TYPE_BITS-1:0] pack_attr(input cyc_attr_t a);
    logic [TYPE_BITS-1:0] v;
    v[0] = a.wr;
    v[1] = a.data;
    v[2] = a.mem;
    v[3] = a.lock;
    v[4] = a.fill;
    return v;
  endfunction

  function automatic logic fault_seen(input logic bus_chk, input logic par_chk,
                                      input logic par_en);
    return bus_chk | (par_chk & par_en);
  endfunction

endpackage

// File: rtl/mcl_detect.sv
module mcl_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_chk_i,
  input  logic par_chk_i,
  input  logic par_en_i,
  input  logic mce_i,
  output logic err_o,
  output logic req_o
);
  import mcl_pkg::*;

  logic req_q;

  assign err_o = fault_seen(bus_chk_i, par_chk_i, par_en_i);

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= err_o & mce_i;
  end

  assign req_o = req_q;
endmodule

// File: rtl/mcl_capture.sv
module mcl_capture #(
  parameter int PADDR_W = 32,
  parameter int REG_W   = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 err_i,
  input  logic [PADDR_W-1:0]   addr_i,
  input  mcl_pkg::cyc_attr_t   attr_i,
  output logic [REG_W-1:0]     addr_q_o,
  output logic [REG_W-1:0]     type_q_o,
  output logic [REG_W-1:0]     addr_nxt_o,
  output logic [REG_W-1:0]     type_nxt_o
);
  import mcl_pkg::*;

  function automatic logic [REG_W-1:0] widen_addr(input logic [PADDR_W-1:0] a);
    return REG_W'(a);
  endfunction

  function automatic logic [REG_W-1:0] widen_type(input cyc_attr_t a);
    return REG_W'(pack_attr(a));
  endfunction

  logic [REG_W-1:0] addr_q, type_q;

  always_comb begin
    addr_nxt_o = addr_q;
    type_nxt_o = type_q;
    if (err_i) begin
      addr_nxt_o = widen_addr(addr_i);
      type_nxt_o = widen_type(attr_i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      type_q <= '0;
    end else begin
      addr_q <= addr_nxt_o;
      type_q <= type_nxt_o;
    end
  end

  assign addr_q_o = addr_q;
  assign type_q_o = type_q;
endmodule

// File: rtl/mcl_readport.sv
module mcl_readport #(
  parameter int REG_W = 64,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [REG_W-1:0] addr_nxt_i,
  input  logic [REG_W-1:0] type_nxt_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  import mcl_pkg::*;

  localparam logic [IDX_W-1:0] SEL_ADDR = IDX_W'(IDX_ADDR);
  localparam logic [IDX_W-1:0] SEL_TYPE = IDX_W'(IDX_TYPE);

  logic [REG_W-1:0] sel_data;
  logic [REG_W-1:0] data_q;
  logic             valid_q;

  always_comb begin
    if (rd_idx_i == SEL_ADDR)      sel_data = addr_nxt_i;
    else if (rd_idx_i == SEL_TYPE) sel_data = type_nxt_i;
    else                           sel_data = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en_i;
      if (rd_en_i) data_q <= sel_data;
    end
  end

  assign rd_data_o  = data_q;
  assign rd_valid_o = valid_q;
endmodule

// File: rtl/buserr_mc_logger.sv
module buserr_mc_logger #(
  parameter int PADDR_W = 32,
  parameter int REG_W   = 64,
  parameter int IDX_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_chk_i,
  input  logic               par_chk_i,
  input  logic               par_en_i,
  input  logic               mce_i,
  input  logic [PADDR_W-1:0] cyc_addr_i,
  input  logic               cyc_wr_i,
  input  logic               cyc_data_i,
  input  logic               cyc_mem_i,
  input  logic               cyc_lock_i,
  input  logic               cyc_fill_i,
  input  logic               rd_en_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [REG_W-1:0]   rd_data_o,
  output logic               rd_valid_o,
  output logic               mc_req_o
);
  import mcl_pkg::*;

  logic               err_w;
  cyc_attr_t          attr_w;
  logic [REG_W-1:0]   addr_q, type_q, addr_nxt, type_nxt;

  assign attr_w = '{fill: cyc_fill_i, lock: cyc_lock_i, mem: cyc_mem_i,
                    data: cyc_data_i, wr: cyc_wr_i};

  mcl_detect u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_chk_i (bus_chk_i),
    .par_chk_i (par_chk_i),
    .par_en_i  (par_en_i),
    .mce_i     (mce_i),
    .err_o     (err_w),
    .req_o     (mc_req_o)
  );

  mcl_capture #(.PADDR_W(PADDR_W), .REG_W(REG_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_i      (err_w),
    .addr_i     (cyc_addr_i),
    .attr_i     (attr_w),
    .addr_q_o   (addr_q),
    .type_q_o   (type_q),
    .addr_nxt_o (addr_nxt),
    .type_nxt_o (type_nxt)
  );

  mcl_readport #(.REG_W(REG_W), .IDX_W(IDX_W)) u_read (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (rd_en_i),
    .rd_idx_i   (rd_idx_i),
    .addr_nxt_i (addr_nxt),
    .type_nxt_i (type_nxt),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );
endmodule

// File: rtl/mcl_checker.sv
module mcl_checker #(
  parameter int REG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_chk_i,
  input logic             par_chk_i,
  input logic             par_en_i,
  input logic             mce_i,
  input logic             rd_en_i,
  input logic             rd_valid_o,
  input logic             mc_req_o,
  input logic             err_w,
  input logic [REG_W-1:0] addr_q,
  input logic [REG_W-1:0] type_q
);
  AST_REQ_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_w && mce_i) |=> mc_req_o); // R5
  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_w) |=> !mc_req_o); // R5
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (err_w && !mce_i) |=> !mc_req_o); // R6
  AST_LONE_PARITY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_chk_i && !(par_chk_i && par_en_i)) |=> ($stable(addr_q) && $stable(type_q))); // R3
  AST_HOLD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_w) |=> $stable(addr_q)); // R9
  AST_ADDR_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q[REG_W-1:32] == '0); // R2
  AST_TYPE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    type_q[REG_W-1:5] == '0); // R4
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o); // R7
endmodule

bind buserr_mc_logger mcl_checker #(.REG_W(REG_W)) u_mcl_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_chk_i  (bus_chk_i),
  .par_chk_i  (par_chk_i),
  .par_en_i   (par_en_i),
  .mce_i      (mce_i),
  .rd_en_i    (rd_en_i),
  .rd_valid_o (rd_valid_o),
  .mc_req_o   (mc_req_o),
  .err_w      (err_w),
  .addr_q     (addr_q),
  .type_q     (type_q)
);

// File: tb/test_buserr_mc_logger.sv
module test_buserr_mc_logger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_chk_i = 0, par_chk_i = 0, par_en_i = 0, mce_i = 0;
  logic [31:0] cyc_addr_i = '0;
  logic        cyc_wr_i = 0, cyc_data_i = 0, cyc_mem_i = 0, cyc_lock_i = 0, cyc_fill_i = 0;
  logic        rd_en_i = 0;
  logic [7:0]  rd_idx_i = '0;
  logic [63:0] rd_data_o;
  logic        rd_valid_o, mc_req_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [63:0] m_addr = '0, m_type = '0, m_rd = '0;
  bit done = 0;

  always #2 clk = ~clk;

  buserr_mc_logger i_buserr_mc_logger (.*);

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_type(input logic [4:0] a);
    return {59'd0, a[4], a[3], a[2], a[1], a[0]};
  endfunction

  // a = {fill, lock, mem, data, wr}
  task automatic cycle(input string tag, input logic bc, input logic pc, input logic pe,
                       input logic en, input logic [31:0] ad, input logic [4:0] a,
                       input logic rd, input logic [7:0] idx);
    logic err, ereq;
    bus_chk_i = bc; par_chk_i = pc; par_en_i = pe; mce_i = en; cyc_addr_i = ad;
    cyc_wr_i = a[0]; cyc_data_i = a[1]; cyc_mem_i = a[2]; cyc_lock_i = a[3]; cyc_fill_i = a[4];
    rd_en_i = rd; rd_idx_i = idx;
    @(posedge clk); #1;
    err = bc | (pc & pe);
    if (err) begin
      m_addr = {32'd0, ad};
      m_type = exp_type(a);
    end
    ereq = err & en;
    if (rd) m_rd = (idx == 8'h00) ? m_addr : (idx == 8'h01) ? m_type : 64'd0;
    chk(tag, "mc_req_o", {63'd0, mc_req_o}, {63'd0, ereq});
    chk(tag, "rd_valid_o", {63'd0, rd_valid_o}, {63'd0, rd});
    chk(tag, "rd_data_o", rd_data_o, m_rd);
    bus_chk_i = 0; par_chk_i = 0; par_en_i = 0; rd_en_i = 0;
  endtask

  task automatic idle(input string tag);
    cycle(tag, 0, 0, 0, 1, 32'h0, 5'h0, 0, 8'h0);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1", "mc_req_o", {63'd0, mc_req_o}, 64'd0);
    chk("R1", "rd_valid_o", {63'd0, rd_valid_o}, 64'd0);
    chk("R1", "rd_data_o", rd_data_o, 64'd0);
    rst_n = 1'b1;
    cycle("R1", 0, 0, 0, 1, 32'h0, 5'h0, 1, 8'h00);
    cycle("R1", 0, 0, 0, 1, 32'h0, 5'h0, 1, 8'h01);
    // R2 R5: bus-check error with enable
    cycle("R5", 1, 0, 0, 1, 32'hDEADBEEF, 5'b00101, 0, 8'h0);
    cycle("R5", 0, 0, 0, 1, 32'h0, 5'h0, 1, 8'h00);
    cycle("R2", 0, 0, 0, 1, 32'h0, 5'h0, 1, 8'h01);
    // R4: each attribute bit alone
    for (int b = 0; b < 5; b++) begin
      cycle("R4", 1, 0, 0, 0, 32'h100 + b, 5'(1 << b), 0, 8'h0);
      cycle("R4", 0, 0, 0, 0, 32'h0, 5'h0, 1, 8'h01);
    end
    // R3: lone parity signals ignored, both together recognised
    cycle("R3", 0, 1, 0, 1, 32'h11111111, 5'h1F, 0, 8'h0);
    cycle("R3", 0, 0, 1, 1, 32'h22222222, 5'h1F, 0, 8'h0);
    cycle("R3", 0, 0, 0, 1, 32'h0, 5'h0, 1, 8'h00);
    cycle("R3", 0, 1, 1, 1, 32'h33333333, 5'h0A, 0, 8'h0);
    cycle("R3", 0, 0, 0, 1, 32'h0, 5'h0, 1, 8'h00);
    // R6: disabled, capture still happens
    cycle("R6", 1, 0, 0, 0, 32'hCAFEF00D, 5'h13, 0, 8'h0);
    cycle("R6", 0, 0, 0, 0, 32'h0, 5'h0, 1, 8'h00);
    cycle("R6", 0, 0, 0, 0, 32'h0, 5'h0, 1, 8'h01);
    // R8: error and read at the same edge
    cycle("R8", 1, 0, 0, 1, 32'hFFFFFFFF, 5'h1F, 1, 8'h00);
    cycle("R8", 0, 1, 1, 1, 32'h00000001, 5'h04, 1, 8'h01);
    // R9: back-to-back errors, last wins
    cycle("R9", 1, 0, 0, 1, 32'hAAAA0000, 5'h01, 0, 8'h0);
    cycle("R9", 1, 0, 0, 1, 32'h5555FFFF, 5'h02, 0, 8'h0);
    idle("R9");
    cycle("R9", 0, 0, 0, 1, 32'h0, 5'h0, 1, 8'h00);
    // R7: unknown index reads zero, data holds without a read
    cycle("R7", 0, 0, 0, 1, 32'h0, 5'h0, 1, 8'h02);
    cycle("R7", 0, 0, 0, 1, 32'h0, 5'h0, 1, 8'hFF);
    cycle("R7", 0, 0, 0, 1, 32'h0, 5'h0, 1, 8'h00);
    idle("R7");
    idle("R7");
    // random mix
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ix;
      ix = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 2);
      cycle("R9", ($urandom % 6) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
            $urandom, 5'($urandom), ($urandom % 3) == 0, ix);
    end
    done = 1;
    report();
  end
endmodule